// File: doc/BRIEF.md
# Processor Control Instruction Unit

This unit executes the one-byte control instructions of a 16-bit CISC core. A fetch stage offers an opcode byte with a valid/ready handshake. The unit keeps the carry, direction and interrupt-enable flags. It drives a halted indication and a bus-lock output, and it signals completion once the fixed number of clocks for the instruction has passed. The wait instruction polls an active-low external test pin. A halted core is woken by an interrupt request, but only while interrupts are enabled.

Opcodes outside the control map are handed back at once on a pass-through port with a one-cycle not-handled strobe, so that other execution units can take them. Reset is synchronous and active high.

Top module: `pcu_ctrl_unit`

## Requirements
- R1: While and after reset, all three flags are 0, `halted` and `lock_out` are 0, `done` and `unhandled` are 0, and `op_ready` is 1.
- R2: Opcode 0xF9 sets carry, 0xF8 clears it and 0xF5 inverts it. No other flag changes.
- R3: Opcode 0xFD sets direction and 0xFC clears it. No other flag changes.
- R4: Opcode 0xFB sets interrupt-enable and 0xFA clears it. No other flag changes.
- R5: A flag instruction, 0x90 (no-op) or 0xF0 (lock) takes 2 clocks. The handshake cycle is clock 1. `done` is high for exactly clock 2, and `op_ready` is low in that cycle. The new flag values are visible from the cycle after `done`.
- R6: Opcode 0x9B (wait) takes 6 clocks when `test_n` is low, so `done` is high in the 5th cycle after the handshake cycle. While `test_n` is high once the count has expired, `done` stays low. `done` rises in the first cycle in which `test_n` is low.
- R7: Opcode 0xF4 (halt) raises `halted` in the 2nd cycle after the handshake cycle and never pulses `done`. While halted, `op_ready` is low. `irq` ends the halt on the next clock only when interrupt-enable is 1. With interrupt-enable 0, `irq` is ignored.
- R8: After opcode 0xF0 completes, `lock_out` is high from the cycle after the next accepted opcode through that instruction's completion cycle. It is low again in the following cycle.
- R9: Any other opcode is accepted with `op_ready` kept high. In the next cycle `unhandled` is high for one cycle with `unhandled_op` equal to the opcode. `done` stays low and no flag changes.
- R10: Opcode 0x90 pulses `done` and changes no flag. `irq` while not halted changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode byte offered |
| op_data | input | 8 | Opcode byte |
| op_ready | output | 1 | Unit can accept an opcode |
| test_n | input | 1 | Active-low test pin polled by wait |
| irq | input | 1 | Interrupt request, wakes a halted unit when enabled |
| done | output | 1 | One-cycle completion strobe |
| unhandled | output | 1 | One-cycle strobe for an opcode outside the map |
| unhandled_op | output | 8 | Opcode returned with `unhandled` |
| carry | output | 1 | Carry flag |
| direction | output | 1 | Direction flag |
| int_en | output | 1 | Interrupt-enable flag |
| halted | output | 1 | Halted state |
| lock_out | output | 1 | Bus lock for the instruction after the lock prefix |

## Verification
The bench sweeps all 256 opcode values twice and tracks the flags, the lock prefix and the cycle counts in its own model. Each of the following errors would break at least one check in the sweep. A decoder that maps one byte to the wrong flag would change the wrong bit. An off-by-one counter would move `done` by one cycle. A lock that is consumed by the wrong instruction, or cleared too late, would show `lock_out` in the wrong cycles.

The bench then holds `test_n` high to show that wait stalls and completes in the very cycle the pin falls. It also tries to wake a halted unit with interrupts disabled, which a careless wake path would honour. Finally, it checks that `irq` outside the halted state leaves everything untouched.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int OP_W = 8;

    typedef enum logic [3:0] {
        K_NONE,
        K_CLC,
        K_STC,
        K_CMC,
        K_CLD,
        K_STD,
        K_CLI,
        K_STI,
        K_HLT,
        K_WAIT,
        K_LOCK,
        K_NOP
    } op_kind_e;

    typedef struct packed {
        logic cf;
        logic df;
        logic ie;
    } flag_s;

    typedef struct packed {
        op_kind_e kind;
        logic     known;
    } dec_s;

    // Map one opcode byte to its operation class.
    function automatic dec_s decode_op(input logic [OP_W-1:0] b);
        dec_s d;
        d.known = 1'b1;
        case (b)
            8'hF8:   d.kind = K_CLC;
            8'hF9:   d.kind = K_STC;
            8'hF5:   d.kind = K_CMC;
            8'hFC:   d.kind = K_CLD;
            8'hFD:   d.kind = K_STD;
            8'hFA:   d.kind = K_CLI;
            8'hFB:   d.kind = K_STI;
            8'hF4:   d.kind = K_HLT;
            8'h9B:   d.kind = K_WAIT;
            8'hF0:   d.kind = K_LOCK;
            8'h90:   d.kind = K_NOP;
            default: begin
                d.kind  = K_NONE;
                d.known = 1'b0;
            end
        endcase
        return d;
    endfunction

    // Flag state after an operation completes.
    function automatic flag_s next_flags(input flag_s f, input op_kind_e k);
        flag_s n;
        n = f;
        case (k)
            K_CLC:   n.cf = 1'b0;
            K_STC:   n.cf = 1'b1;
            K_CMC:   n.cf = ~f.cf;
            K_CLD:   n.df = 1'b0;
            K_STD:   n.df = 1'b1;
            K_CLI:   n.ie = 1'b0;
            K_STI:   n.ie = 1'b1;
            default: n = f;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [OP_W-1:0] op_byte,
    output op_kind_e        kind,
    output logic            known
);
    dec_s d;

    always_comb begin
        d     = decode_op(op_byte);
        kind  = d.kind;
        known = d.known;
    end

    always_comb begin
        if (!known) begin
            assert_unknown_class_R9: assert (kind == K_NONE);
        end
    end
endmodule

// File: rtl/pcu_flags.sv
module pcu_flags
    import pcu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     apply,
    input  op_kind_e kind,
    output flag_s    flags
);
    flag_s q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (apply) begin
            q <= next_flags(q, kind);
        end
    end

    assign flags = q;

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(q));

    assert_reset_flags_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_single_flag_R2: assert property (@(posedge clk) disable iff (rst)
        apply |=> ($countones(q ^ $past(q)) <= 1));
endmodule

// File: rtl/pcu_seq.sv
module pcu_seq
    import pcu_pkg::*;
#(
    parameter int SHORT_CYC = 2,
    parameter int WAIT_CYC  = 6,
    parameter int CNT_W     = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_byte,
    input  op_kind_e        kind_in,
    input  logic            known_in,
    input  logic            test_n,
    input  logic            irq,
    input  logic            ie,
    output logic            op_ready,
    output logic            fin,
    output op_kind_e        cur_kind,
    output logic            done,
    output logic            nh_strb,
    output logic [OP_W-1:0] nh_op,
    output logic            halted,
    output logic            lock_out
);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 2);
    localparam logic [CNT_W-1:0] WAIT_LOAD  = CNT_W'(WAIT_CYC - 2);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    op_kind_e         kind_q;
    logic             halt_q;
    logic             armed_q;
    logic             lock_q;
    logic             nh_q;
    logic [OP_W-1:0]  nh_op_q;
    logic             acc;
    logic             cnt_zero;

    assign op_ready = !busy_q && !halt_q;
    assign acc      = op_valid && op_ready;
    assign cnt_zero = (cnt_q == '0);
    assign fin      = busy_q && cnt_zero && ((kind_q != K_WAIT) || !test_n);
    assign done     = fin && (kind_q != K_HLT);
    assign cur_kind = kind_q;
    assign nh_strb  = nh_q;
    assign nh_op    = nh_op_q;
    assign halted   = halt_q;
    assign lock_out = lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            kind_q  <= K_NONE;
            halt_q  <= 1'b0;
            armed_q <= 1'b0;
            lock_q  <= 1'b0;
            nh_q    <= 1'b0;
            nh_op_q <= '0;
        end else begin
            nh_q <= 1'b0;
            if (acc) begin
                if (known_in) begin
                    busy_q <= 1'b1;
                    kind_q <= kind_in;
                    cnt_q  <= (kind_in == K_WAIT) ? WAIT_LOAD : SHORT_LOAD;
                end else begin
                    nh_q    <= 1'b1;
                    nh_op_q <= op_byte;
                end
                lock_q  <= armed_q;
                armed_q <= 1'b0;
            end else if (busy_q) begin
                if (fin) begin
                    busy_q <= 1'b0;
                    lock_q <= 1'b0;
                    if (kind_q == K_HLT) begin
                        halt_q <= 1'b1;
                    end
                    if (kind_q == K_LOCK) begin
                        armed_q <= 1'b1;
                    end
                end else if (!cnt_zero) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (nh_q) begin
                lock_q <= 1'b0;
            end
            if (halt_q && irq && ie) begin
                halt_q <= 1'b0;
            end
        end
    end

    assert_done_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !op_ready);

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, nh_strb}));

    assert_halt_silent_R7: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!done && !op_ready));

    assert_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (halted && irq && ie) |=> !halted);

    assert_halt_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (halted && !ie) |=> halted);

    assert_wait_block_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && kind_q == K_WAIT && test_n) |-> !done);

    assert_lock_drop_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !lock_out);

    assert_nh_ready_R9: assert property (@(posedge clk) disable iff (rst)
        nh_strb |-> (op_ready || busy_q));
endmodule

// File: rtl/pcu_ctrl_unit.sv
module pcu_ctrl_unit
    import pcu_pkg::*;
#(
    parameter int SHORT_CYC = 2,
    parameter int WAIT_CYC  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [7:0] op_data,
    output logic       op_ready,
    input  logic       test_n,
    input  logic       irq,
    output logic       done,
    output logic       unhandled,
    output logic [7:0] unhandled_op,
    output logic       carry,
    output logic       direction,
    output logic       int_en,
    output logic       halted,
    output logic       lock_out
);
    localparam int CNT_W = $clog2((WAIT_CYC > SHORT_CYC ? WAIT_CYC : SHORT_CYC) + 1);

    op_kind_e dec_kind;
    logic     dec_known;
    op_kind_e cur_kind;
    logic     fin;
    flag_s    flags;

    pcu_decode u_dec (
        .op_byte (op_data),
        .kind    (dec_kind),
        .known   (dec_known)
    );

    pcu_seq #(
        .SHORT_CYC (SHORT_CYC),
        .WAIT_CYC  (WAIT_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_byte  (op_data),
        .kind_in  (dec_kind),
        .known_in (dec_known),
        .test_n   (test_n),
        .irq      (irq),
        .ie       (flags.ie),
        .op_ready (op_ready),
        .fin      (fin),
        .cur_kind (cur_kind),
        .done     (done),
        .nh_strb  (unhandled),
        .nh_op    (unhandled_op),
        .halted   (halted),
        .lock_out (lock_out)
    );

    pcu_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .apply (fin),
        .kind  (cur_kind),
        .flags (flags)
    );

    assign carry     = flags.cf;
    assign direction = flags.df;
    assign int_en    = flags.ie;

    assert_reset_out_R1: assert property (@(posedge clk)
        rst |=> (!halted && !lock_out && !done && !unhandled && op_ready));
endmodule

// File: tb/pcu_ctrl_unit_tb_top.sv
module pcu_ctrl_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] op_data = 8'h00;
    logic       test_n = 1'b0;
    logic       irq = 1'b0;
    logic       op_ready, done, unhandled, carry, direction, int_en, halted, lock_out;
    logic [7:0] unhandled_op;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic m_cf = 0, m_df = 0, m_ie = 0, m_armed = 0;

    always #10 clk = ~clk;

    pcu_ctrl_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_data(op_data),
        .op_ready(op_ready), .test_n(test_n), .irq(irq), .done(done),
        .unhandled(unhandled), .unhandled_op(unhandled_op), .carry(carry),
        .direction(direction), .int_en(int_en), .halted(halted), .lock_out(lock_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({carry, direction, int_en} == {m_cf, m_df, m_ie}, req,
            {carry, direction, int_en}, {m_cf, m_df, m_ie});
    endtask

    // Independent flag model.
    task automatic model_apply(input logic [7:0] op);
        case (op)
            8'hF8: m_cf = 0;
            8'hF9: m_cf = 1;
            8'hF5: m_cf = !m_cf;
            8'hFC: m_df = 0;
            8'hFD: m_df = 1;
            8'hFA: m_ie = 0;
            8'hFB: m_ie = 1;
            default: ;
        endcase
    endtask

    function automatic bit in_map(input logic [7:0] op);
        return op inside {8'hF8, 8'hF9, 8'hF5, 8'hFC, 8'hFD, 8'hFA, 8'hFB,
                          8'hF4, 8'h9B, 8'hF0, 8'h90};
    endfunction

    // Offer op, return at the negedge following the accepting edge.
    task automatic offer(input logic [7:0] op);
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_valid = 1;
        op_data  = op;
        @(posedge clk);
        @(negedge clk);
        op_valid = 0;
    endtask

    // Run a non-halt op and check timing, lock and flags.
    task automatic run_op(input logic [7:0] op, input string req);
        logic lk;
        int   lat;
        lk = m_armed;
        m_armed = 0;
        offer(op);
        if (in_map(op)) begin
            lat = 1;
            while (!done && lat < 40) begin
                chk(lock_out == lk, "R8 lock during op", lock_out, lk);
                @(negedge clk);
                lat++;
            end
            chk(lock_out == lk, "R8 lock at completion", lock_out, lk);
            chk(lat == ((op == 8'h9B) ? 5 : 1), {req, " R5/R6 latency"}, lat,
                (op == 8'h9B) ? 5 : 1);
            @(negedge clk);
            model_apply(op);
            if (op == 8'hF0) m_armed = 1;
            chk_flags({req, " flags"});
            chk(!lock_out && !done, "R8 lock released", lock_out, 0);
        end else begin
            chk(unhandled && unhandled_op == op && !done && op_ready,
                "R9 unhandled strobe", {unhandled, unhandled_op}, {1'b1, op});
            chk(lock_out == lk, "R8 lock on unhandled", lock_out, lk);
            @(negedge clk);
            chk(!unhandled, "R9 strobe one cycle", unhandled, 0);
            chk_flags("R9 flags unchanged");
        end
    endtask

    task automatic do_reset();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        m_cf = 0; m_df = 0; m_ie = 0; m_armed = 0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(!carry && !direction && !int_en && !halted && !lock_out &&
            !done && !unhandled && op_ready, "R1 reset state",
            {carry, direction, int_en, halted, lock_out, done, unhandled, op_ready},
            1);
        rst = 0;

        // Directed flag operations.
        run_op(8'hF9, "R2 set carry");
        run_op(8'hF5, "R2 invert carry");
        run_op(8'hF5, "R2 invert carry back");
        run_op(8'hF8, "R2 clear carry");
        run_op(8'hFD, "R3 set direction");
        run_op(8'hFC, "R3 clear direction");
        run_op(8'hFB, "R4 set int enable");
        run_op(8'hFA, "R4 clear int enable");
        run_op(8'h90, "R10 no-op");
        run_op(8'hF0, "R8 lock prefix");
        run_op(8'hF9, "R8 locked op");
        run_op(8'h37, "R9 unknown");

        // irq outside halt changes nothing (R10).
        irq = 1;
        repeat (3) @(negedge clk);
        irq = 0;
        chk_flags("R10 irq when running");
        chk(!halted && op_ready, "R10 irq when running", halted, 0);

        // Exhaustive sweeps over every opcode except halt.
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 256; v++) begin
                if (v != 8'hF4) run_op(8'(v), "sweep");
            end
        end

        // WAIT stalls while test_n is high (R6).
        test_n = 1;
        offer(8'h9B);
        for (int i = 0; i < 10; i++) begin
            chk(!done, "R6 wait stalls", done, 0);
            @(negedge clk);
        end
        test_n = 0;
        #1;
        chk(done, "R6 wait completes on test low", done, 1);
        @(negedge clk);
        chk(!done && op_ready, "R6 wait ends", done, 0);

        // Halt with interrupts disabled: irq ignored (R7).
        run_op(8'hFA, "R4 before halt");
        offer(8'hF4);
        chk(!halted && !done, "R7 halt busy cycle", halted, 0);
        @(negedge clk);
        chk(halted && !op_ready && !done, "R7 halted", halted, 1);
        irq = 1;
        repeat (4) @(negedge clk);
        chk(halted, "R7 irq ignored with IE clear", halted, 1);
        irq = 0;
        do_reset();
        chk(!halted && op_ready, "R1 reset clears halt", halted, 0);

        // Halt with interrupts enabled: irq wakes (R7).
        run_op(8'hFB, "R4 before halt");
        offer(8'hF4);
        @(negedge clk);
        chk(halted, "R7 halted with IE", halted, 1);
        repeat (3) begin
            @(negedge clk);
            chk(halted && !done, "R7 stays halted", halted, 1);
        end
        irq = 1;
        @(negedge clk);
        irq = 0;
        chk(!halted && op_ready, "R7 irq wakes", halted, 0);
        chk_flags("R7 flags after wake");
        run_op(8'h90, "R10 after wake");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule